// File: doc/BRIEF.md
# Paged Memory Window Decoder

This block maps a 24-bit system memory address into card space through five programmable windows. Each window owns three 16-bit registers: a base register, a map register and a control register. Software writes them over a small register bus and can read them back. The base register places the window on 4 KiB system pages. The map register adds a page offset and chooses attribute or common space. The control register enables the window, routes it to a socket and sets its bus width, wait states and write protection.

The decode is combinational. In the same cycle that a memory cycle is presented, the block reports a hit, the target socket, a 26-bit card address and the cycle attributes. On the clock edge that ends a cycle with a hit, the winning window records in its control register that it has been used. Software clears that record by writing zero to the bit.

Top module: `memwin_decoder`

## Requirements
- R1: After reset, every window register reads zero, and no address produces a hit.
- R2: A register write takes effect on the next clock edge. The write is addressed by `regSel` (window 0..4) and `regKind` (0 = base, 1 = map, 2 = control). `regRdData` returns the addressed register combinationally. A write with `regSel` above 4 or `regKind` = 3 changes nothing, and a read with either of those values returns zero.
- R3: When base bit 14 is set, the window covers exactly one 4 KiB page, and it matches when address bits 23:12 equal base bits 11:0.
- R4: When base bit 14 is clear, let k be the position of the lowest set bit of base bits 11:0 (k = 11 when that field is zero). The window then covers 2^k pages, and it matches when address bits 23:12+k equal base bits 11:k.
- R5: A window whose control bit 15 is clear never hits.
- R6: The card address is {(system page + map bits 13:0) mod 2^14, address bits 11:0}. `attrSpace` equals map bit 15 of the winning window.
- R7: On a hit, `socket` is control bits 14:12, `byteWide` is control bit 11 and `waitStates` is control bits 3:0 of the winning window.
- R8: When several enabled windows match, the window with the lowest number wins.
- R9: `wrBlocked` is high only when a write cycle hits a window whose control bit 7 is set. Such a cycle still reports a hit and its attributes. Read cycles are never blocked.
- R10: Control bit 8 of the winning window is set on the clock edge that ends a cycle with a hit, blocked writes included. Other windows are not affected. A control write with bit 8 at zero clears the bit. A control write with bit 8 at one leaves it unchanged.
- R11: If a control write and a hit on the same window fall in the same cycle, bit 8 ends set, and the decode in that cycle uses the register values from before the write.
- R12: When `cycValid` is low or no window matches, `hit`, `wrBlocked` and every attribute output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Window number for register access |
| regKind | input | 2 | Register kind: 0 base, 1 map, 2 control |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Readback of the addressed register |
| cycValid | input | 1 | A memory cycle is presented |
| cycWrite | input | 1 | The cycle is a write |
| cycAddr | input | 24 | System memory address |
| hit | output | 1 | An enabled window matched |
| socket | output | 3 | Target socket of the winning window |
| cardAddr | output | 26 | Translated card address |
| attrSpace | output | 1 | Cycle goes to attribute space |
| byteWide | output | 1 | 8-bit access selected |
| waitStates | output | 4 | Wait-state count |
| wrBlocked | output | 1 | Write hit on a write-protected window |

## Verification
Two things can change the accessed bit of one window in the same edge: a memory cycle that hits the window, and a software write to its control register. The bench provokes this on purpose. In one cycle it writes the control register of a protected window with bit 8 at zero and also drives a hit on that window. It then reads the register back and expects bit 8 set. It also expects that cycle's decode to follow the old control value. Random traffic mixes register writes into the address stream, so the same collision also occurs with base and map writes. A behavioural model applies the hardware set after the software write, and every clock is compared against it.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
  localparam int REG_W = 16;

  // control register bit positions
  localparam int CTL_EN      = 15;
  localparam int CTL_SOCK_LO = 12;
  localparam int CTL_BYTE    = 11;
  localparam int CTL_ACC     = 8;
  localparam int CTL_WP      = 7;
  // base and map register bit positions
  localparam int BASE_ONEPG  = 14;
  localparam int MAP_ATTR    = 15;

  typedef enum logic [1:0] {
    KIND_BASE = 2'd0,
    KIND_MAP  = 2'd1,
    KIND_CTL  = 2'd2,
    KIND_NONE = 2'd3
  } regKindT;

  typedef struct packed {
    logic wrBase;
    logic wrMap;
    logic wrCtl;
  } winStrobeT;
endpackage

// File: rtl/memwin_busctl.sv
module memwin_busctl
  import memwin_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [SEL_W-1:0] regSel,
  input  logic [1:0]       regKind,
  output winStrobeT        strobes [NUM_WIN],
  output logic             rdValid
);
  logic idxOk;
  logic [NUM_WIN-1:0] wrAny;

  assign idxOk   = int'(regSel) < NUM_WIN;
  assign rdValid = idxOk && (regKind != KIND_NONE);

  for (genvar g = 0; g < NUM_WIN; g++) begin : gStrobe
    logic sel;
    assign sel = regWrEn && idxOk && (int'(regSel) == g);
    assign strobes[g].wrBase = sel && (regKind == KIND_BASE);
    assign strobes[g].wrMap  = sel && (regKind == KIND_MAP);
    assign strobes[g].wrCtl  = sel && (regKind == KIND_CTL);
    assign wrAny[g] = strobes[g].wrBase | strobes[g].wrMap | strobes[g].wrCtl;
  end

  // R2: at most one window receives a write per cycle
  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrAny));
endmodule

// File: rtl/memwin_slot.sv
module memwin_slot
  import memwin_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int OFS_W  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobeT         strobe,
  input  logic [REG_W-1:0]  wrData,
  input  logic [PAGE_W-1:0] cycPage,
  input  logic              accSet,
  output logic [REG_W-1:0]  baseQ,
  output logic [REG_W-1:0]  mapQ,
  output logic [REG_W-1:0]  ctlQ,
  output logic              matchNow,
  output logic [OFS_W-1:0]  cardPage
);
  logic [PAGE_W-1:0] baseField;
  logic [PAGE_W-1:0] ignMask;

  assign baseField = baseQ[PAGE_W-1:0];
  // pages below the lowest set base bit are inside the window
  assign ignMask = baseQ[BASE_ONEPG] ? '0 :
    ((baseField ^ (baseField - {{(PAGE_W-1){1'b0}}, 1'b1})) >> 1);
  assign matchNow = ctlQ[CTL_EN] && ((cycPage & ~ignMask) == (baseField & ~ignMask));
  assign cardPage = {{(OFS_W-PAGE_W){1'b0}}, cycPage} + mapQ[OFS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      mapQ  <= '0;
      ctlQ  <= '0;
    end else begin
      if (strobe.wrBase) baseQ <= wrData;
      if (strobe.wrMap)  mapQ  <= wrData;
      if (strobe.wrCtl) begin
        ctlQ <= wrData;
        ctlQ[CTL_ACC] <= (ctlQ[CTL_ACC] & wrData[CTL_ACC]) | accSet;
      end else if (accSet) begin
        ctlQ[CTL_ACC] <= 1'b1;
      end
    end
  end

  // R10: a winning access leaves the accessed bit set
  assert_acc_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    accSet |=> ctlQ[CTL_ACC]);
  // R2: control register only moves on a write or an access
  assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrCtl && !accSet) |=> $stable(ctlQ));
endmodule

// File: rtl/memwin_datapath.sv
module memwin_datapath
  import memwin_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int SEL_W   = 3,
  parameter int ADDR_W  = 24,
  parameter int PG_SH   = 12,
  parameter int OFS_W   = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  winStrobeT          strobes [NUM_WIN],
  input  logic               rdValid,
  input  logic [SEL_W-1:0]   regSel,
  input  logic [1:0]         regKind,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic               cycValid,
  input  logic               cycWrite,
  input  logic [ADDR_W-1:0]  cycAddr,
  output logic               hit,
  output logic [2:0]         socket,
  output logic [OFS_W+PG_SH-1:0] cardAddr,
  output logic               attrSpace,
  output logic               byteWide,
  output logic [3:0]         waitStates,
  output logic               wrBlocked
);
  localparam int PAGE_W = ADDR_W - PG_SH;

  logic [REG_W-1:0] baseArr [NUM_WIN];
  logic [REG_W-1:0] mapArr  [NUM_WIN];
  logic [REG_W-1:0] ctlArr  [NUM_WIN];
  logic [OFS_W-1:0] pageArr [NUM_WIN];
  logic [NUM_WIN-1:0] matchVec;
  logic [NUM_WIN-1:0] grant;
  logic [SEL_W-1:0]   winIdx;
  logic found;

  for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
    memwin_slot #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) uSlot (
      .clk(clk), .rstN(rstN), .strobe(strobes[g]), .wrData(regWrData),
      .cycPage(cycAddr[ADDR_W-1:PG_SH]), .accSet(cycValid && grant[g]),
      .baseQ(baseArr[g]), .mapQ(mapArr[g]), .ctlQ(ctlArr[g]),
      .matchNow(matchVec[g]), .cardPage(pageArr[g]));

    // R5: only an enabled window can be granted
    assert_grant_enabled_R5: assert property (@(posedge clk) disable iff (!rstN)
      grant[g] |-> ctlArr[g][CTL_EN]);
  end

  // fixed priority: lowest window number first
  always_comb begin
    grant  = '0;
    found  = 1'b0;
    winIdx = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (!found && matchVec[i]) begin
        grant[i] = 1'b1;
        found    = 1'b1;
        winIdx   = SEL_W'(i);
      end
    end
  end

  always_comb begin
    hit        = cycValid && found;
    socket     = '0;
    cardAddr   = '0;
    attrSpace  = 1'b0;
    byteWide   = 1'b0;
    waitStates = '0;
    wrBlocked  = 1'b0;
    if (hit) begin
      socket     = ctlArr[winIdx][CTL_SOCK_LO +: 3];
      cardAddr   = {pageArr[winIdx], cycAddr[PG_SH-1:0]};
      attrSpace  = mapArr[winIdx][MAP_ATTR];
      byteWide   = ctlArr[winIdx][CTL_BYTE];
      waitStates = ctlArr[winIdx][3:0];
      wrBlocked  = cycWrite && ctlArr[winIdx][CTL_WP];
    end
  end

  always_comb begin
    regRdData = '0;
    if (rdValid) begin
      case (regKind)
        KIND_BASE: regRdData = baseArr[regSel];
        KIND_MAP:  regRdData = mapArr[regSel];
        default:   regRdData = ctlArr[regSel];
      endcase
    end
  end

  // R8: never more than one winner
  assert_one_winner_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  // R9: blocking needs a write that hits
  assert_block_on_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrBlocked |-> (hit && cycWrite));
  // R12: nothing is reported without a presented cycle
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !cycValid |-> (!hit && !wrBlocked && cardAddr == '0));
endmodule

// File: rtl/memwin_decoder.sv
module memwin_decoder
  import memwin_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int ADDR_W  = 24,
  parameter int PG_SH   = 12,
  parameter int OFS_W   = 14,
  localparam int SEL_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CARD_W = OFS_W + PG_SH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [1:0]        regKind,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic              cycValid,
  input  logic              cycWrite,
  input  logic [ADDR_W-1:0] cycAddr,
  output logic              hit,
  output logic [2:0]        socket,
  output logic [CARD_W-1:0] cardAddr,
  output logic              attrSpace,
  output logic              byteWide,
  output logic [3:0]        waitStates,
  output logic              wrBlocked
);
  winStrobeT strobes [NUM_WIN];
  logic rdValid;

  memwin_busctl #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) uCtl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regKind(regKind), .strobes(strobes), .rdValid(rdValid));

  memwin_datapath #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
                    .PG_SH(PG_SH), .OFS_W(OFS_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdValid(rdValid),
    .regSel(regSel), .regKind(regKind), .regWrData(regWrData),
    .regRdData(regRdData), .cycValid(cycValid), .cycWrite(cycWrite),
    .cycAddr(cycAddr), .hit(hit), .socket(socket), .cardAddr(cardAddr),
    .attrSpace(attrSpace), .byteWide(byteWide), .waitStates(waitStates),
    .wrBlocked(wrBlocked));
endmodule

// File: tb/tb_memwin_decoder.sv
module tb_memwin_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regSel = '0;
  logic [1:0] regKind = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic cycValid = 1'b0;
  logic cycWrite = 1'b0;
  logic [23:0] cycAddr = '0;
  logic hit, attrSpace, byteWide, wrBlocked;
  logic [2:0] socket;
  logic [25:0] cardAddr;
  logic [3:0] waitStates;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [15:0] mBase [5];
  logic [15:0] mMap  [5];
  logic [15:0] mCtl  [5];

  always #10 clk = ~clk;

  memwin_decoder dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regKind(regKind),
    .regWrData(regWrData), .regRdData(regRdData), .cycValid(cycValid),
    .cycWrite(cycWrite), .cycAddr(cycAddr), .hit(hit), .socket(socket),
    .cardAddr(cardAddr), .attrSpace(attrSpace), .byteWide(byteWide),
    .waitStates(waitStates), .wrBlocked(wrBlocked));

  function automatic bit mMatch(int i, logic [11:0] pg);
    int k;
    if (!mCtl[i][15]) return 0;
    if (mBase[i][14]) return pg == mBase[i][11:0];
    k = 11;
    for (int b = 11; b >= 0; b--) if (mBase[i][b]) k = b;
    return (pg >> k) == (mBase[i][11:0] >> k);
  endfunction

  function automatic int mWinner();
    if (!cycValid) return -1;
    for (int i = 0; i < 5; i++) if (mMatch(i, cycAddr[23:12])) return i;
    return -1;
  endfunction

  bit bad;
  task automatic cmp(string tag, string req, string fld, logic [31:0] got, logic [31:0] exp);
    if (got !== exp) begin
      $display("FAIL %s [%s] %s got %h expected %h", req, tag, fld, got, exp);
      bad = 1;
    end
  endtask

  task automatic step(string tag);
    int w;
    logic [15:0] eRd;
    logic [13:0] ePg;
    @(negedge clk);
    bad = 0;
    w = mWinner();
    eRd = 16'h0;
    if (regSel < 5 && regKind != 2'd3)
      eRd = (regKind == 2'd0) ? mBase[regSel] : (regKind == 2'd1) ? mMap[regSel] : mCtl[regSel];
    cmp(tag, "R2", "regRdData", 32'(regRdData), 32'(eRd));
    if (w < 0) begin
      cmp(tag, "R12", "hit", 32'(hit), 0);
      cmp(tag, "R12", "cardAddr", 32'(cardAddr), 0);
      cmp(tag, "R12", "socket", 32'(socket), 0);
      cmp(tag, "R12", "attr", 32'({attrSpace, byteWide, waitStates, wrBlocked}), 0);
    end else begin
      ePg = 14'(cycAddr[23:12]) + mMap[w][13:0];
      cmp(tag, "R4", "hit", 32'(hit), 1);
      cmp(tag, "R6", "cardAddr", 32'(cardAddr), 32'({ePg, cycAddr[11:0]}));
      cmp(tag, "R6", "attrSpace", 32'(attrSpace), 32'(mMap[w][15]));
      cmp(tag, "R7", "socket", 32'(socket), 32'(mCtl[w][14:12]));
      cmp(tag, "R7", "byteWide", 32'(byteWide), 32'(mCtl[w][11]));
      cmp(tag, "R7", "waitStates", 32'(waitStates), 32'(mCtl[w][3:0]));
      cmp(tag, "R9", "wrBlocked", 32'(wrBlocked), 32'(cycWrite && mCtl[w][7]));
    end
    vectors++;
    if (bad) miscompares++;
    @(posedge clk);
    // model update: software write first, then the hardware set (R11)
    if (regWrEn && regSel < 5) begin
      case (regKind)
        2'd0: mBase[regSel] = regWrData;
        2'd1: mMap[regSel] = regWrData;
        2'd2: begin
          logic keep;
          keep = mCtl[regSel][8] & regWrData[8];
          mCtl[regSel] = regWrData;
          mCtl[regSel][8] = keep;
        end
        default: ;
      endcase
    end
    if (w >= 0) mCtl[w][8] = 1'b1;
    #1;
  endtask

  task automatic wr(int sel, int kind, logic [15:0] d, string tag);
    regWrEn = 1; regSel = 3'(sel); regKind = 2'(kind); regWrData = d;
    cycValid = 0;
    step(tag);
    regWrEn = 0;
  endtask

  task automatic rd(int sel, int kind, string tag);
    regSel = 3'(sel); regKind = 2'(kind); cycValid = 0;
    step(tag);
  endtask

  task automatic acc(logic [23:0] a, bit isWr, string tag);
    cycValid = 1; cycWrite = isWr; cycAddr = a;
    step(tag);
    cycValid = 0; cycWrite = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      $display("FAIL watchdog expired");
      miscompares++;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin mBase[i] = 0; mMap[i] = 0; mCtl[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1: cleared state
    for (int i = 0; i < 5; i++) rd(i, 2, "R1 reset ctl");
    acc(24'h000123, 0, "R1 no hit after reset");
    acc(24'hFFF000, 0, "R1 no hit high");
    // R2: programming, readback, ignored accesses
    wr(0, 0, 16'h4012, "R2 base0");
    wr(0, 1, 16'h8005, "R2 map0");
    wr(0, 2, 16'hA803, "R2 ctl0");
    rd(0, 0, "R2 rd base0"); rd(0, 1, "R2 rd map0"); rd(0, 2, "R2 rd ctl0");
    wr(6, 0, 16'hFFFF, "R2 bad index write");
    rd(6, 0, "R2 bad index read");
    wr(1, 3, 16'hFFFF, "R2 bad kind write");
    rd(1, 3, "R2 bad kind read");
    rd(1, 0, "R2 neighbour untouched");
    // R3 single page
    acc(24'h012ABC, 0, "R3 page hit");
    acc(24'h013000, 0, "R12 next page miss");
    acc(24'h011FFF, 0, "R12 prev page miss");
    // R6 card page wrap
    wr(1, 0, 16'h4FFF, "R6 base1"); wr(1, 1, 16'h3FFF, "R6 map1"); wr(1, 2, 16'h8000, "R6 ctl1");
    acc(24'hFFF555, 0, "R6 wrap");
    // R4 sized window, 64 pages at 0x040
    wr(2, 0, 16'h0040, "R4 base2"); wr(2, 2, 16'h9000, "R4 ctl2");
    acc(24'h07F010, 0, "R4 top page");
    acc(24'h040000, 0, "R4 bottom page");
    acc(24'h080000, 0, "R4 above miss");
    acc(24'h03F000, 0, "R4 below miss");
    // R8 overlap priority
    wr(3, 0, 16'h4050, "R8 base3"); wr(3, 1, 16'h0100, "R8 map3"); wr(3, 2, 16'hB00F, "R8 ctl3");
    acc(24'h050123, 0, "R8 lower wins");
    // R5 disable the lower window
    wr(2, 2, 16'h1000, "R5 ctl2 off");
    acc(24'h050123, 0, "R5 upper now wins");
    acc(24'h060000, 0, "R5 disabled miss");
    // R9 write protect
    wr(4, 0, 16'h4100, "R9 base4"); wr(4, 2, 16'h8080, "R9 ctl4");
    acc(24'h100004, 1, "R9 write blocked");
    acc(24'h100004, 0, "R9 read passes");
    // R10 accessed bit
    rd(4, 2, "R10 acc set");
    rd(1, 2, "R10 other untouched");
    wr(4, 2, 16'h8180, "R10 write one keeps");
    rd(4, 2, "R10 still set");
    wr(4, 2, 16'h8080, "R10 write zero clears");
    rd(4, 2, "R10 cleared");
    // R11 collision: clear and hit together
    regWrEn = 1; regSel = 3'd4; regKind = 2'd2; regWrData = 16'h0080;
    cycValid = 1; cycWrite = 1; cycAddr = 24'h100FFF;
    step("R11 clear and hit same cycle");
    regWrEn = 0; cycValid = 0; cycWrite = 0;
    rd(4, 2, "R11 set wins");
    acc(24'h100000, 0, "R11 new ctl in force");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int w;
      regWrEn = ($urandom % 8) == 0;
      regSel = 3'($urandom % 8);
      regKind = 2'($urandom % 4);
      regWrData = 16'($urandom);
      cycValid = ($urandom % 4) != 0;
      cycWrite = 1'($urandom);
      cycAddr = 24'($urandom);
      if ($urandom % 2) begin
        w = $urandom % 5;
        cycAddr[23:12] = mBase[w][11:0] | 12'($urandom % 4);
      end
      step("random R8 R10 R11");
    end
    regWrEn = 0; cycValid = 0;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule